// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling Serial Result Port

This block is the digital side of a two-channel, 12-bit, simultaneous-sampling converter's serial port, written so it can drive a host controller in simulation. Two 12-bit two's complement values stand in for the analog results. An active-low chip select frames each conversion. A host-driven serial clock paces both the conversion and the shifting of bits. Each serial data line has its own output enable, so a pad or a bench can tri-state it.

Inside the block, a control module watches chip select and the serial clock on a fast system clock. It counts the serial clock falling edges of the frame and issues strobes to a datapath. The datapath holds both samples from the same instant and chooses the bit to drive on each line. One conversion is 16 falling edges. The first four drive null (zero) bits, and the hold point is at the fourth. The next twelve edges carry the result, most significant bit first. In dual-line mode the two channels go out in parallel. In single-line mode channel A's word and then channel B's word go out on line A over 32 edges. While chip select stays low, conversions follow one another without a gap.

Top module: `dual_adc_serial_port`

## Requirements
- R1: One system clock after chip select goes high, both enables are low and both data lines read 0. While chip select is low, line A's enable is high and line B's enable equals the mode latched for the frame.
- R2: If the serial clock is low when chip select falls, that chip select fall is counted as falling edge 1. If the serial clock is high, edge 1 is the next serial clock fall.
- R3: Falling edges 1 to 4 of every word drive 0 on each enabled data line.
- R4: Falling edges 5 to 16 of a word drive sample bits 11 down to 0, most significant bit first. The two's complement value is sent unchanged, so 0x7FF sends 0 then eleven 1s, and 0x800 sends 1 then eleven 0s.
- R5: Both samples are captured together at falling edge 4 of a conversion. A sample input that changes after that edge does not alter the word being sent.
- R6: With the mode input high (dual-line), line A carries channel A's word and line B carries channel B's word on the same edges.
- R7: With the mode input low (single-line), a conversion lasts 32 falling edges. Line A sends 4 nulls, channel A's 12 bits, 4 nulls, then channel B's 12 bits, and both channels are sampled at edge 4. Line B's enable stays low and its data stays 0.
- R8: While chip select stays low, the edge after the last edge of a conversion (edge 17 in dual-line mode, 33 in single-line mode) is edge 1 of the next conversion, and that conversion captures fresh samples at its own fourth edge.
- R9: If chip select rises before a conversion completes, the conversion is abandoned and the outputs disable. The next chip select fall starts again at edge 1 with a fresh capture.
- R10: The mode input is latched at the chip select fall. A change to it while chip select stays low has no effect on the frame.
- R11: After reset both enables are low and both data lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select; frames conversions |
| sclk | input | 1 | Serial clock from the host |
| modeDual | input | 1 | 1 = dual-line output, 0 = both words on line A |
| sampleA | input | 12 | Channel A result, two's complement |
| sampleB | input | 12 | Channel B result, two's complement |
| dataA | output | 1 | Serial data line A |
| dataB | output | 1 | Serial data line B |
| enA | output | 1 | Output enable for line A |
| enB | output | 1 | Output enable for line B |

## Verification
The bench goes after edge counting at the frame start. If chip select falls with the serial clock low and the design ignores that fall as a first edge, every bit arrives one position late. It changes the sample inputs just after the hold edge, and again between back-to-back conversions. A design that reads the inputs live would send mixed words, and one that captures only once per frame would repeat the stale result. It also aborts a frame part way and flips the mode input in mid-frame. A design with a counter that is not cleared would resume mid-word, and one with an unlatched mode would switch line B on or off during a word.

// File: rtl/dual_adc_port_pkg.sv
package dual_adc_port_pkg;
  localparam int SAMPLE_W    = 12;
  localparam int NULL_BITS   = 4;
  localparam int NUM_CH      = 2;
  localparam int WORD_CYCLES = SAMPLE_W + NULL_BITS;
  localparam int CNT_W       = $clog2(2 * WORD_CYCLES);
  localparam int POS_W       = $clog2(WORD_CYCLES);

  typedef struct packed {
    logic             tick;
    logic             capture;
    logic             clear;
    logic             isNull;
    logic             wordSel;
    logic             dualMode;
    logic [POS_W-1:0] bitPos;
  } strobe_t;
endpackage

// File: rtl/dual_adc_port_ctrl.sv
module dual_adc_port_ctrl
  import dual_adc_port_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    csN,
  input  logic    sclk,
  input  logic    modeDual,
  output strobe_t st,
  output logic    enA,
  output logic    enB
);
  logic csPrev;
  logic sclkPrev;
  logic dualQ;
  logic [CNT_W-1:0] cnt;

  logic csFall;
  logic sclkFall;
  logic tick;
  logic curDual;
  logic [CNT_W-1:0] cntEff;
  logic [CNT_W-1:0] wordPos;
  logic [CNT_W-1:0] lastIdx;
  logic nullPos;

  always_comb begin
    csFall   = csPrev & ~csN;
    sclkFall = sclkPrev & ~sclk;
    tick     = (csFall & ~sclk) | (~csN & ~csFall & sclkFall);
    curDual  = csFall ? modeDual : dualQ;
    cntEff   = csFall ? '0 : cnt;
    wordPos  = (cntEff >= CNT_W'(WORD_CYCLES)) ? cntEff - CNT_W'(WORD_CYCLES) : cntEff;
    lastIdx  = curDual ? CNT_W'(WORD_CYCLES - 1) : CNT_W'(2 * WORD_CYCLES - 1);
    nullPos  = wordPos < CNT_W'(NULL_BITS);

    st.tick     = tick;
    st.capture  = tick & (cntEff == CNT_W'(NULL_BITS - 1));
    st.clear    = csN;
    st.isNull   = nullPos;
    st.wordSel  = cntEff >= CNT_W'(WORD_CYCLES);
    st.dualMode = curDual;
    st.bitPos   = nullPos ? '0 : POS_W'(WORD_CYCLES - 1) - POS_W'(wordPos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
      dualQ    <= 1'b1;
      cnt      <= '0;
      enA      <= 1'b0;
      enB      <= 1'b0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
      if (csFall) dualQ <= modeDual;
      if (csN) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= (cntEff == lastIdx) ? '0 : cntEff + 1'b1;
      end
      enA <= ~csN;
      enB <= ~csN & curDual;
    end
  end

  // R8: in dual-line mode the count wraps within one 16-edge word
  assert_dual_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dualQ && !csN) |-> (cnt < CNT_W'(WORD_CYCLES)));

  // R5: the hold point is a counted edge inside the null field
  assert_capture_null_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st.capture |-> (st.isNull && st.tick));

  // R9: chip select high returns the edge count to the start
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csN |=> (cnt == '0));

  // R10: mode stays fixed while the frame continues
  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && !csFall) |=> $stable(dualQ));
endmodule

// File: rtl/dual_adc_port_dp.sv
module dual_adc_port_dp
  import dual_adc_port_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t st,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] samples,
  output logic    dataA,
  output logic    dataB
);
  logic [SAMPLE_W-1:0] holdQ [NUM_CH];
  logic nextA;
  logic nextB;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n) holdQ[ch] <= '0;
      else if (st.capture) holdQ[ch] <= samples[ch];
    end
  end

  always_comb begin
    if (st.isNull) nextA = 1'b0;
    else if (st.dualMode || !st.wordSel) nextA = holdQ[0][st.bitPos];
    else nextA = holdQ[1][st.bitPos];
    nextB = (!st.isNull && st.dualMode) ? holdQ[1][st.bitPos] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st.clear) begin
      dataA <= 1'b0;
      dataB <= 1'b0;
    end else if (st.tick) begin
      dataA <= nextA;
      dataB <= nextB;
    end
  end

  // R3: a null edge drives zero on both lines
  assert_null_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st.tick && st.isNull && !st.clear) |=> (!dataA && !dataB));

  // R7: single-line mode leaves line B at zero
  assert_lineb_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st.tick && !st.dualMode) |=> !dataB);
endmodule

// File: rtl/dual_adc_serial_port.sv
module dual_adc_serial_port
  import dual_adc_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csN,
  input  logic                sclk,
  input  logic                modeDual,
  input  logic [SAMPLE_W-1:0] sampleA,
  input  logic [SAMPLE_W-1:0] sampleB,
  output logic                dataA,
  output logic                dataB,
  output logic                enA,
  output logic                enB
);
  strobe_t st;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] samples;

  assign samples = {sampleB, sampleA};

  dual_adc_port_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .modeDual(modeDual),
    .st(st), .enA(enA), .enB(enB)
  );

  dual_adc_port_dp u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .samples(samples),
    .dataA(dataA), .dataB(dataB)
  );

  // R1: a high chip select switches both lines off on the next clock
  assert_off_when_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    csN |=> (!enA && !enB && !dataA && !dataB));

  // R7: line B is never enabled without line A
  assert_enb_implies_ena_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enB |-> enA);
endmodule

// File: tb/dual_adc_serial_port_bench.sv
module dual_adc_serial_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic modeDual = 1'b1;
  logic [11:0] sampleA = '0;
  logic [11:0] sampleB = '0;
  logic dataA, dataB, enA, enB;

  int tests = 0;
  int fails = 0;
  logic [63:0] shA, shB;

  always #2 clk = ~clk;

  dual_adc_serial_port u_dual_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .modeDual(modeDual),
    .sampleA(sampleA), .sampleB(sampleB),
    .dataA(dataA), .dataB(dataB), .enA(enA), .enB(enB)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sampleLines();
    shA = {shA[62:0], dataA};
    shB = {shB[62:0], dataB};
  endtask

  task automatic beginFrame(input bit dual, input bit lowAtFall);
    @(negedge clk);
    modeDual = dual;
    sclk = lowAtFall ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    csN = 1'b0;
    shA = '0;
    shB = '0;
    repeat (2) @(negedge clk);
    if (lowAtFall) begin
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sampleLines();
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sampleLines();
    end
  endtask

  task automatic endFrame();
    csN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 enables off", {62'b0, enA, enB}, 64'd0);
    chk("R1 data low", {62'b0, dataA, dataB}, 64'd0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R11 reset outputs", {60'b0, enA, enB, dataA, dataB}, 64'd0);
  endtask

  task automatic testDual(input bit lowAtFall, input logic [11:0] a, input logic [11:0] b);
    sampleA = a;
    sampleB = b;
    beginFrame(1'b1, lowAtFall);
    chk("R1 R6 enables on", {62'b0, enA, enB}, 64'd3);
    edges(lowAtFall ? 15 : 16);
    chk(lowAtFall ? "R2 R4 line A" : "R3 R4 R6 line A", {48'b0, shA[15:0]}, {52'b0, a});
    chk("R3 R6 line B", {48'b0, shB[15:0]}, {52'b0, b});
    endFrame();
  endtask

  task automatic testHold();
    logic [11:0] a = 12'hA5C;
    logic [11:0] b = 12'h3E1;
    sampleA = a;
    sampleB = b;
    beginFrame(1'b1, 1'b0);
    edges(4);
    sampleA = ~a;
    sampleB = ~b;
    edges(12);
    chk("R5 hold A", {48'b0, shA[15:0]}, {52'b0, a});
    chk("R5 hold B", {48'b0, shB[15:0]}, {52'b0, b});
    endFrame();
  endtask

  task automatic testSingle(input logic [11:0] a, input logic [11:0] b);
    sampleA = a;
    sampleB = b;
    beginFrame(1'b0, 1'b0);
    chk("R7 line B enable off", {62'b0, enA, enB}, 64'd2);
    edges(32);
    chk("R7 single line A", {32'b0, shA[31:0]}, {32'b0, 4'b0, a, 4'b0, b});
    chk("R7 line B quiet", {32'b0, shB[31:0]}, 64'd0);
    chk("R7 enable B still off", {63'b0, enB}, 64'd0);
    endFrame();
  endtask

  task automatic testContDual();
    logic [11:0] a0 = 12'h123, b0 = 12'hFED, a1 = 12'h9AB, b1 = 12'h456;
    sampleA = a0;
    sampleB = b0;
    beginFrame(1'b1, 1'b0);
    edges(16);
    sampleA = a1;
    sampleB = b1;
    edges(16);
    chk("R8 continuous A", {32'b0, shA[31:0]}, {32'b0, 4'b0, a0, 4'b0, a1});
    chk("R8 continuous B", {32'b0, shB[31:0]}, {32'b0, 4'b0, b0, 4'b0, b1});
    endFrame();
  endtask

  task automatic testContSingle();
    logic [11:0] a0 = 12'h0F0, b0 = 12'h811, a1 = 12'h7EE, b1 = 12'h00C;
    sampleA = a0;
    sampleB = b0;
    beginFrame(1'b0, 1'b0);
    edges(32);
    sampleA = a1;
    sampleB = b1;
    edges(32);
    chk("R8 R7 continuous single",
        shA, {4'b0, a0, 4'b0, b0, 4'b0, a1, 4'b0, b1});
    endFrame();
  endtask

  task automatic testAbort();
    sampleA = 12'h555;
    sampleB = 12'h2AA;
    beginFrame(1'b1, 1'b0);
    edges(9);
    csN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 abort disables", {60'b0, enA, enB, dataA, dataB}, 64'd0);
    sampleA = 12'hC37;
    sampleB = 12'h1D4;
    beginFrame(1'b1, 1'b0);
    edges(16);
    chk("R9 restart A", {48'b0, shA[15:0]}, {52'b0, 12'hC37});
    chk("R9 restart B", {48'b0, shB[15:0]}, {52'b0, 12'h1D4});
    endFrame();
  endtask

  task automatic testModeFlip();
    sampleA = 12'h6B2;
    sampleB = 12'hE19;
    beginFrame(1'b1, 1'b0);
    edges(6);
    modeDual = 1'b0;
    edges(10);
    chk("R10 mode ignored A", {48'b0, shA[15:0]}, {52'b0, 12'h6B2});
    chk("R10 mode ignored B", {48'b0, shB[15:0]}, {52'b0, 12'hE19});
    chk("R10 enable B kept", {63'b0, enB}, 64'd1);
    endFrame();
    modeDual = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    for (int i = 0; i < 4; i++) testDual(1'b0, 12'($urandom), 12'($urandom));
    testDual(1'b1, 12'($urandom), 12'($urandom));
    testDual(1'b0, 12'h7FF, 12'h800);
    testDual(1'b1, 12'h800, 12'h7FF);
    testHold();
    testSingle(12'($urandom), 12'($urandom));
    testSingle(12'h800, 12'h7FF);
    testContDual();
    testContSingle();
    testAbort();
    testModeFlip();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule